// File: doc/BRIEF.md
# Local-Mean Image Binarizer

This block turns a raster stream of 8-bit grayscale pixels into a stream of one-bit pixels. Each output bit is 1 when its pixel is brighter than the mean of the 16x16 neighbourhood around it, and 0 otherwise. A threshold that follows local brightness keeps edges and texture in a one-bit form. Later stages can then compare image blocks with XOR and a population count.

Pixels arrive with a valid strobe and a start-of-frame flag, one row after another. Fifteen row buffers hold the rows above the current one. A 16-tap column adder forms a vertical sum for every column, and two banks of column sums take turns: one is filled while the other is swept with a running horizontal sum. The window spans 8 pixels before and 7 after the centre on both axes. Outside the frame the nearest edge pixel is used in its place, so every input pixel yields exactly one output bit. After the last pixel of a frame, the block produces the final 8 rows of output by itself.

Top module: `local_mean_binarizer`

## Requirements
- R1: While reset is asserted and right after it is released, out_valid, out_sof and out_eol are low.
- R2: The output bit for pixel (x,y) is 1 exactly when 256*p(x,y) is greater than the sum of the pixels in rows y-8..y+7 and columns x-8..x+7.
- R3: A pixel equal to its local mean gives 0, so a frame of one uniform value gives an all-zero output.
- R4: A window position outside the frame takes the value of the pixel on the nearest edge: the row index is clamped to 0..HEIGHT-1 and the column index to 0..WIDTH-1.
- R5: Each frame gives exactly WIDTH*HEIGHT output bits, in raster order, and none beyond.
- R6: out_sof is high with the output for pixel (0,0) only. out_eol is high with every output for column WIDTH-1 only. Both are high only when out_valid is high.
- R7: The output for pixel (x,y) appears one clock after the accepted input beat of pixel (x,y+8). With unbroken input, out_sof follows the input start-of-frame by 8*WIDTH+1 clocks. The first input pixel of a frame gives no output on the next clock.
- R8: After the last pixel of a frame, the block emits the remaining 8 rows on its own, one bit every clock for 8*WIDTH clocks. The last bit appears 8*WIDTH+1 clocks after the last input pixel, and in_valid must stay low until then.
- R9: Clocks with in_valid low outside that drain give no output and do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | 8 | Grayscale pixel |
| out_valid | output | 1 | Output bit valid |
| out_sof | output | 1 | Marks the output of pixel (0,0) |
| out_eol | output | 1 | Marks the output of the last column of a row |
| out_bit | output | 1 | 1 when the pixel exceeds its local mean |

## Verification
Random frames exercise the comparison across a wide spread of values. Uniform frames at 100 and 255, and a narrow-band random frame, check that a pixel equal to its mean gives 0. A dark frame with single bright pixels in two corners and a gradient frame show whether edge replication is right: a wrong clamp changes the bits near the borders. Frames with random gaps in in_valid are checked against the same bench model, and exact output timing is checked against the input start and the last input pixel.

// File: rtl/local_mean_binarizer.sv
module local_mean_binarizer #(
  parameter int WIDTH  = 720,
  parameter int HEIGHT = 480
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_pix,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eol,
  output logic       out_bit
);
  localparam int CW = $clog2(WIDTH);
  localparam int RW = $clog2(HEIGHT + 8);

  logic [CW-1:0] col, ccol, ia, ib;
  logic [RW-1:0] row, crow;
  logic          flushing, bank, tick, sof_now, last_col;
  logic [7:0]    top_rd, cur;
  logic [7:0]    chain [16];
  logic [11:0]   vsum, va, vb;
  logic [19:0]   acc, sumr;
  logic [11:0]   vb0 [WIDTH];
  logic [11:0]   vb1 [WIDTH];

  assign sof_now  = in_valid && in_sof && !flushing;
  assign tick     = flushing || in_valid;
  assign ccol     = sof_now ? '0 : col;
  assign crow     = sof_now ? '0 : row;
  assign last_col = ccol == CW'(WIDTH - 1);
  assign cur      = flushing ? top_rd : in_pix;
  assign chain[0] = cur;

  for (genvar k = 0; k < 15; k++) begin : g_line
    logic [7:0] mem [WIDTH];
    assign chain[k+1] = mem[ccol];
    always_ff @(posedge clk)
      if (tick) mem[ccol] <= chain[k];
    if (k == 0) begin : g_first
      assign top_rd = mem[ccol];
    end
  end

  always_comb begin
    vsum = '0;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] sel;
      sel  = (k > int'(crow)) ? crow[3:0] : 4'(k);
      vsum = vsum + 12'(chain[sel]);
    end
  end

  assign ia = (ccol >= CW'(WIDTH - 8)) ? CW'(WIDTH - 1) : ccol + CW'(8);
  assign ib = (ccol < CW'(8)) ? '0 : ccol - CW'(8);
  assign va = bank ? vb0[ia] : vb1[ia];
  assign vb = bank ? vb0[ib] : vb1[ib];

  always_ff @(posedge clk)
    if (tick) begin
      if (bank) vb1[ccol] <= vsum;
      else      vb0[ccol] <= vsum;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col       <= '0;
      row       <= '0;
      flushing  <= 1'b0;
      bank      <= 1'b0;
      acc       <= '0;
      sumr      <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= tick && crow >= RW'(8);
      out_sof   <= tick && crow == RW'(8) && ccol == '0;
      out_eol   <= tick && crow >= RW'(8) && last_col;
      out_bit   <= 20'({chain[8], 8'h00}) > sumr;
      if (tick) begin
        col <= last_col ? '0 : ccol + CW'(1);
        if (ccol == '0)        acc <= 20'(vsum) * 20'd9;
        else if (ccol < CW'(8)) acc <= acc + 20'(vsum);
        sumr <= last_col ? acc : sumr + 20'(va) - 20'(vb);
        if (last_col) begin
          bank <= ~bank;
          row  <= (crow == RW'(HEIGHT + 7)) ? '0 : crow + RW'(1);
          if (crow == RW'(HEIGHT - 1)) flushing <= 1'b1;
          if (crow == RW'(HEIGHT + 7)) flushing <= 1'b0;
        end
      end
    end
  end

  a_r6_markers_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eol) |-> out_valid);
  a_r8_no_input_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !in_valid);
  a_r8_drain_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> out_valid);
  a_r9_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !flushing) |=> !out_valid);
  a_r7_first_pixel_silent: assert property (@(posedge clk) disable iff (!rst_n)
    sof_now |=> !out_valid);
endmodule

// File: tb/local_mean_binarizer_bench.sv
`timescale 1ns/1ps
module local_mean_binarizer_bench;
  localparam int W = 20;
  localparam int H = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_sof;
  logic [7:0] in_pix;
  logic out_valid, out_sof, out_eol, out_bit;

  local_mean_binarizer #(.WIDTH(W), .HEIGHT(H)) u_local_mean_binarizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_bit(out_bit));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int img [H][W];
  int checks = 0, errors = 0, oidx = 0, sof_drive = 0, last_drive = 0, mode = 0;
  bit gapped = 1'b0, done = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (out index %0d)", req, act, exp, oidx);
    end
  endtask

  function automatic int clampi(int v, int hi);
    return v < 0 ? 0 : (v > hi ? hi : v);
  endfunction

  function automatic bit exp_bit(int x, int y);
    int s = 0;
    for (int dy = -8; dy < 8; dy++)
      for (int dx = -8; dx < 8; dx++)
        s += img[clampi(y + dy, H - 1)][clampi(x + dx, W - 1)];
    return img[y][x] * 256 > s;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int x, y;
      string lab;
      x = oidx % W;
      y = oidx / W;
      if (oidx >= W * H) check(1'b0, "R5", oidx, W * H - 1);
      else begin
        lab = gapped ? "R9" : (mode == 1 || mode == 4 || mode == 5) ? "R3" :
              (x < 8 || y < 8 || x > W - 9 || y > H - 9) ? "R4" : "R2";
        check(out_bit == exp_bit(x, y), lab, out_bit, exp_bit(x, y));
        check(out_sof == (oidx == 0), "R6", out_sof, oidx == 0);
        check(out_eol == (x == W - 1), "R6", out_eol, x == W - 1);
        if (out_sof && !gapped) check(cyc == sof_drive + 8 * W + 1, "R7", cyc, sof_drive + 8 * W + 1);
        if (oidx == W * H - 1) check(cyc == last_drive + 8 * W + 1, "R8", cyc, last_drive + 8 * W + 1);
      end
      oidx++;
    end
  end

  task automatic send_frame(int m, bit gaps);
    mode = m;
    gapped = gaps;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        case (m)
          0: img[y][x] = int'($urandom % 256);
          1: img[y][x] = 100;
          2: img[y][x] = ((x == 0 && y == 0) || (x == W - 1 && y == H - 1)) ? 255 : 0;
          3: img[y][x] = x * 12 + y;
          4: img[y][x] = 255;
          default: img[y][x] = 120 + int'($urandom % 8);
        endcase
    oidx = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if (gaps)
          while ($urandom % 3 == 0) begin
            in_valid = 1'b0;
            in_sof = 1'b0;
            @(negedge clk);
          end
        in_valid = 1'b1;
        in_pix = 8'(img[y][x]);
        in_sof = (x == 0 && y == 0);
        if (in_sof) sof_drive = cyc;
        last_drive = cyc;
        @(negedge clk);
      end
    in_valid = 1'b0;
    in_sof = 1'b0;
    repeat (8 * W + 6) @(negedge clk);
    check(oidx == W * H, "R5", oidx, W * H);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_pix = '0;
    repeat (3) @(negedge clk);
    check({out_valid, out_sof, out_eol} == 3'b000, "R1", {out_valid, out_sof, out_eol}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({out_valid, out_sof, out_eol} == 3'b000, "R1", {out_valid, out_sof, out_eol}, 0);
    send_frame(0, 1'b0);
    send_frame(1, 1'b0);
    send_frame(2, 1'b0);
    send_frame(3, 1'b0);
    send_frame(4, 1'b0);
    send_frame(5, 1'b0);
    send_frame(0, 1'b1);
    send_frame(3, 1'b1);
    send_frame(2, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 60000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule